// File: doc/BRIEF.md
# Inter-core doorbell mailbox bank

A bank of sixteen 32-bit doorbell registers that carries inter-processor interrupts in a four-core cluster. Every core owns four mailboxes. A core that wants to signal another writes a bitmask to the target mailbox through its set window, and the mailbox ORs the mask into its contents. The receiving core reads the mailbox, handles the bits it finds, and then writes those bits back through the clear window to drop them.

Each mailbox drives a level flag that stays high while any of its bits is 1. An interrupt router downstream uses these flags and applies its own enables and delivery class. Two identical register ports give access to the bank, so a set and a clear can reach the same mailbox in the same cycle. Reads return registered data one cycle after the request.

Top module: `doorbell_bank`

## Requirements
- R1: While reset is held and on the first cycle after it, every mailbox is zero, every flag is low, `rvalid_o` is low and `rdata_o` is zero.
- R2: A write to byte address 0x80 + 16·c + 4·m sets mailbox (c, m) to its old value OR the write data. Bits written as 0 have no effect. The new value is visible from the next cycle.
- R3: A write to byte address 0xC0 + 16·c + 4·m clears exactly the bits of mailbox (c, m) that are 1 in the write data. All other bits keep their value.
- R4: Bit 4·c + m of `nz_o` is 1 exactly when mailbox (c, m) holds a nonzero value, counted from the cycle after the write that changed it.
- R5: A read request (`req_i` high, `we_i` low) on a port raises that port's `rvalid_o` on the next cycle. `rdata_o` then holds the mailbox contents as they were before any write in the request cycle. This holds at both the set address and the clear address.
- R6: Reads change no mailbox and no flag.
- R7: When a set and a clear from different ports hit the same mailbox in one cycle, any bit named by both ends up 1.
- R8: Set writes from both ports to the same mailbox in one cycle are both applied (their masks are ORed in). Clears from both ports to the same mailbox are likewise both applied.
- R9: An access below 0x80, or one whose two low address bits are not 00, is ignored when it is a write. When it is a read, it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 2 | Access request, one bit per port |
| we_i | input | 2 | Write enable, one bit per port |
| addr_i | input | 16 | Byte address, 8 bits per port, port 0 in the low byte |
| wdata_i | input | 64 | Write data, 32 bits per port, port 0 in the low word |
| rdata_o | output | 64 | Registered read data, 32 bits per port |
| rvalid_o | output | 2 | Read data valid, one cycle after a read request |
| nz_o | output | 16 | Nonzero flag per mailbox, index 4·c + m |

## Verification
The bench targets a set and a clear that collide on the same bit from the two ports. A design that let the clear win would lose a doorbell that was just rung. It also drives two sets that land on one mailbox together: a design that kept only one port's mask would drop the other sender's bits. The bench reads in the same cycle as a write to that mailbox, which exposes read data that bypasses the register. It also makes misaligned and out-of-window accesses, which a loose decoder would alias onto a real mailbox.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } win_e;
endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
  import doorbell_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_BOX = 16,
  parameter logic [ADDR_W-1:0] SET_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] CLR_BASE = 8'hC0,
  localparam int IDX_W = $clog2(NUM_BOX),
  localparam int WIN_BYTES = NUM_BOX * 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output win_e              win_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0] off_s, off_c;
  logic in_s, in_c;

  assign off_s = addr_i - SET_BASE;
  assign off_c = addr_i - CLR_BASE;
  assign in_s = (addr_i >= SET_BASE) && ({1'b0, off_s} < (ADDR_W+1)'(WIN_BYTES))
                && (off_s[1:0] == 2'b00);
  assign in_c = (addr_i >= CLR_BASE) && ({1'b0, off_c} < (ADDR_W+1)'(WIN_BYTES))
                && (off_c[1:0] == 2'b00);

  always_comb begin
    win_o = WIN_NONE;
    idx_o = '0;
    if (in_c) begin
      win_o = WIN_CLR;
      idx_o = off_c[IDX_W+1:2];
    end else if (in_s) begin
      win_o = WIN_SET;
      idx_o = off_s[IDX_W+1:2];
    end
  end
endmodule

// File: rtl/doorbell_cell.sv
module doorbell_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] q_o,
  output logic              nz_o
);
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q & ~clr_i) | set_i;  // set dominates
  end

  assign q_o  = q_q;
  assign nz_o = |q_q;

  assert_set_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_q & $past(set_i)) == $past(set_i)));
  assert_clear_only_named_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_q & $past(clr_i & ~set_i)) == '0));
  assert_set_beats_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & clr_i)) |=> ((q_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));
  assert_idle_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(q_q));
endmodule

// File: rtl/doorbell_rport.sv
module doorbell_rport
  import doorbell_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_BOX = 16,
  localparam int IDX_W = $clog2(NUM_BOX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  win_e              win_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] box_i [NUM_BOX],
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= (win_i == WIN_NONE) ? '0 : box_i[idx_i];
    end
  end

  assert_read_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  assert_no_spurious_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  assert_miss_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && win_i == WIN_NONE) |=> (rdata_o == '0));
endmodule

// File: rtl/doorbell_bank.sv
module doorbell_bank
  import doorbell_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int BOX_PER_CORE = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NUM_PORTS = 2,
  parameter logic [ADDR_W-1:0] SET_BASE = 8'h80,
  parameter logic [ADDR_W-1:0] CLR_BASE = 8'hC0,
  localparam int NUM_BOX = NUM_CORES * BOX_PER_CORE,
  localparam int IDX_W = $clog2(NUM_BOX)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_PORTS-1:0]          req_i,
  input  logic [NUM_PORTS-1:0]          we_i,
  input  logic [NUM_PORTS*ADDR_W-1:0]   addr_i,
  input  logic [NUM_PORTS*DATA_W-1:0]   wdata_i,
  output logic [NUM_PORTS*DATA_W-1:0]   rdata_o,
  output logic [NUM_PORTS-1:0]          rvalid_o,
  output logic [NUM_BOX-1:0]            nz_o
);
  win_e              win  [NUM_PORTS];
  logic [IDX_W-1:0]  idx  [NUM_PORTS];
  logic [DATA_W-1:0] box  [NUM_BOX];
  logic [DATA_W-1:0] set_m [NUM_BOX];
  logic [DATA_W-1:0] clr_m [NUM_BOX];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    doorbell_decode #(
      .ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_dec (
      .addr_i(addr_i[p*ADDR_W +: ADDR_W]),
      .win_o (win[p]),
      .idx_o (idx[p])
    );

    doorbell_rport #(.DATA_W(DATA_W), .NUM_BOX(NUM_BOX)) u_rd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rd_i    (req_i[p] & ~we_i[p]),
      .win_i   (win[p]),
      .idx_i   (idx[p]),
      .box_i   (box),
      .rdata_o (rdata_o[p*DATA_W +: DATA_W]),
      .rvalid_o(rvalid_o[p])
    );

    assert_set_raises_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[p] && we_i[p] && win[p] == WIN_SET && wdata_i[p*DATA_W +: DATA_W] != '0)
      |=> nz_o[$past(idx[p])]);
  end

  // Merge every port's write into per-mailbox set and clear masks
  always_comb begin
    for (int i = 0; i < NUM_BOX; i++) begin
      set_m[i] = '0;
      clr_m[i] = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (req_i[p] && we_i[p] && idx[p] == IDX_W'(i)) begin
          if (win[p] == WIN_SET) set_m[i] = set_m[i] | wdata_i[p*DATA_W +: DATA_W];
          if (win[p] == WIN_CLR) clr_m[i] = clr_m[i] | wdata_i[p*DATA_W +: DATA_W];
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
    doorbell_cell #(.DATA_W(DATA_W)) u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_m[i]),
      .clr_i (clr_m[i]),
      .q_o   (box[i]),
      .nz_o  (nz_o[i])
    );
  end

  assert_no_write_no_flag_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i & we_i) == '0) |=> $stable(nz_o));
endmodule

// File: tb/sim_doorbell_bank.sv
`timescale 1ns/1ps
module sim_doorbell_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req = '0, we = '0;
  logic [15:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [1:0]  rvalid;
  logic [15:0] nz;

  always #2.5 clk = ~clk;

  doorbell_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .nz_o(nz)
  );

  logic [31:0] mb [16];
  logic [31:0] exp_rd [2];
  logic        exp_rv [2];
  int n_chk = 0, n_bad = 0;
  string tag = "R1";

  task automatic decode(input logic [7:0] a, output int win, output int idx);
    win = 0; idx = 0;
    if (a[1:0] == 2'b00 && a >= 8'hC0) begin win = 2; idx = (int'(a) - 'hC0) / 4; end
    else if (a[1:0] == 2'b00 && a >= 8'h80) begin win = 1; idx = (int'(a) - 'h80) / 4; end
  endtask

  task automatic compare();
    logic [15:0] ef;
    for (int i = 0; i < 16; i++) ef[i] = (mb[i] != 0);
    n_chk++;
    if (nz !== ef) begin
      n_bad++;
      $display("FAIL %s (R4 flags): actual %h expected %h", tag, nz, ef);
    end
    for (int p = 0; p < 2; p++) begin
      n_chk++;
      if (rvalid[p] !== exp_rv[p]) begin
        n_bad++;
        $display("FAIL %s (R5 rvalid port %0d): actual %b expected %b", tag, p, rvalid[p], exp_rv[p]);
      end
      if (exp_rv[p]) begin
        n_chk++;
        if (rdata[p*32 +: 32] !== exp_rd[p]) begin
          n_bad++;
          $display("FAIL %s (rdata port %0d): actual %h expected %h", tag, p, rdata[p*32 +: 32], exp_rd[p]);
        end
      end
    end
  endtask

  // Compare outputs of the last edge, drive new inputs, advance model
  task automatic cyc(input logic [1:0] rq, input logic [1:0] w,
                     input logic [7:0] a0, input logic [7:0] a1,
                     input logic [31:0] d0, input logic [31:0] d1);
    logic [31:0] sm [16];
    logic [31:0] cm [16];
    logic [7:0]  a [2];
    logic [31:0] d [2];
    @(negedge clk);
    compare();
    req = rq; we = w; addr = {a1, a0}; wdata = {d1, d0};
    a[0] = a0; a[1] = a1; d[0] = d0; d[1] = d1;
    for (int i = 0; i < 16; i++) begin sm[i] = '0; cm[i] = '0; end
    for (int p = 0; p < 2; p++) begin
      int wn, ix;
      decode(a[p], wn, ix);
      exp_rv[p] = rq[p] && !w[p];
      if (exp_rv[p]) exp_rd[p] = (wn == 0) ? 32'h0 : mb[ix];
      if (rq[p] && w[p] && wn == 1) sm[ix] |= d[p];
      if (rq[p] && w[p] && wn == 2) cm[ix] |= d[p];
    end
    for (int i = 0; i < 16; i++) mb[i] = (mb[i] & ~cm[i]) | sm[i];
  endtask

  function automatic logic [7:0] sa(int c, int m); return 8'(8'h80 + 16*c + 4*m); endfunction
  function automatic logic [7:0] ca(int c, int m); return 8'(8'hC0 + 16*c + 4*m); endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) mb[i] = '0;
    exp_rv[0] = 1'b0; exp_rv[1] = 1'b0; exp_rd[0] = '0; exp_rd[1] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    n_chk++;
    if (nz !== 16'h0 || rvalid !== 2'b00 || rdata !== 64'h0) begin
      n_bad++;
      $display("FAIL R1 reset: actual nz=%h rv=%b rd=%h expected 0", nz, rvalid, rdata);
    end
    rst_n = 1'b1;
    tag = "R1";
    cyc(2'b00, 2'b00, 0, 0, 0, 0);

    // R2: set core 2 mailbox 1, then OR more bits, zero write no effect
    tag = "R2";
    cyc(2'b01, 2'b01, sa(2,1), 0, 32'h0000_0005, 0);
    cyc(2'b01, 2'b01, sa(2,1), 0, 32'h8000_0000, 0);
    cyc(2'b01, 2'b01, sa(2,1), 0, 32'h0, 0);
    // R5: read at both windows, both ports
    tag = "R5";
    cyc(2'b11, 2'b00, sa(2,1), ca(2,1), 0, 0);
    // R5: read same cycle as write returns old value
    cyc(2'b11, 2'b10, sa(2,1), sa(2,1), 0, 32'h0000_0100);
    cyc(2'b01, 2'b00, ca(2,1), 0, 0, 0);
    // R3: clear one bit only
    tag = "R3";
    cyc(2'b10, 2'b10, 0, ca(2,1), 0, 32'h0000_0004);
    cyc(2'b01, 2'b00, ca(2,1), 0, 0, 0);
    // R4: clear all remaining bits, flag drops
    tag = "R4";
    cyc(2'b01, 2'b01, ca(2,1), 0, 32'hFFFF_FFFF, 0);
    cyc(2'b01, 2'b01, sa(3,3), 0, 32'h1, 0);
    cyc(2'b01, 2'b01, sa(0,0), 0, 32'h2, 0);
    // R6: reads leave state alone
    tag = "R6";
    for (int k = 0; k < 4; k++) cyc(2'b11, 2'b00, sa(3,3), ca(0,0), 0, 0);
    // R7: set and clear on the same bit, set wins
    tag = "R7";
    cyc(2'b11, 2'b11, sa(1,2), ca(1,2), 32'h0000_00F0, 32'h0000_0030);
    cyc(2'b11, 2'b11, ca(1,2), sa(1,2), 32'h0000_00C0, 32'h0000_00C0);
    cyc(2'b01, 2'b00, ca(1,2), 0, 0, 0);
    // R8: two sets and two clears on one mailbox
    tag = "R8";
    cyc(2'b11, 2'b11, sa(0,3), sa(0,3), 32'h0000_0011, 32'h0001_0000);
    cyc(2'b11, 2'b11, ca(0,3), ca(0,3), 32'h0000_0001, 32'h0001_0000);
    cyc(2'b01, 2'b00, sa(0,3), 0, 0, 0);
    // R9: misaligned and out-of-window accesses
    tag = "R9";
    cyc(2'b11, 2'b11, 8'h81, 8'h40, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    cyc(2'b11, 2'b11, 8'hC2, 8'h7C, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    cyc(2'b11, 2'b00, 8'h85, 8'h00, 0, 0);
    cyc(2'b11, 2'b00, sa(0,3), ca(1,2), 0, 0);
    // Mixed traffic across all requirements
    tag = "R2/R3/R5/R7/R8 mixed";
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a0, a1;
      a0 = ($urandom % 8 == 0) ? 8'($urandom) : 8'(($urandom % 2 ? 8'h80 : 8'hC0) + ($urandom % 16) * 4);
      a1 = ($urandom % 8 == 0) ? 8'($urandom) : 8'(($urandom % 2 ? 8'h80 : 8'hC0) + ($urandom % 16) * 4);
      cyc(2'($urandom), 2'($urandom), a0, a1, $urandom & $urandom & $urandom, $urandom & $urandom);
    end
    cyc(2'b00, 2'b00, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    summary();
  end
endmodule